// File: doc/BRIEF.md
# Serial Register Port with Burst Readout

This block is the serial-bus face of a measurement unit. An external master clocks 16-bit frames into it over a four-wire SPI link (mode 3, MSB first). Each frame either writes one byte of a 16-bit register or asks for a whole register. The requested word comes back in the following frame, so a master can stream requests and results in full duplex. The registers are byte-addressed: the low byte sits at the even address and the high byte at the odd one.

Two kinds of register matter here. Seven read-only output words carry sensor samples. Each one holds a new-data flag in bit 15, the OR of the error inputs in bit 14, and a 14-bit sample. A bank of read/write control words is presented to the rest of the chip as one flat vector. A read request for byte address 0x3E starts a burst. The seven output words then come back in the frames that follow, in ascending address order, and no request is needed for each one.

Samples enter through a valid/ready stream. `sample_ready` is low for the whole burst, so every word of a burst comes from the same sample. A producer that sees ready low holds `sample_valid` and `sample_data` steady until a cycle in which both are high.

Top module: `spi_regslave`

## Requirements
- R1: A frame is 16 SCLK cycles taken while chip select is low, with SCLK idling high. MOSI is sampled on rising SCLK edges, MSB first. MISO presents the MSB from the start of the frame and moves to the next bit after each falling edge that follows a rising edge of the same frame.
- R2: In a received frame, bit 15 is the direction (1 = write, 0 = read), bits 14:8 are the byte address and bits 7:0 are the write byte. The write byte is ignored on a read.
- R3: A write frame to a control byte address (0x1A to 0x39) changes only that byte: an even address sets bits 7:0 and an odd address sets bits 15:8 of the word. Frame 0xB703 puts 0x03 into bits 15:8 of word 0x36.
- R4: After a read frame, the next frame shifts out the whole 16-bit word that contains the requested byte, whether the address is odd or even.
- R5: The frame after a write frame shifts out 0x0000.
- R6: A read of byte address 0x3E starts a burst. The next seven frames return the output words at 0x04, 0x06, 0x08, 0x0A, 0x0C, 0x0E and 0x10. The content of those seven frames is ignored. The frame after them returns 0x0000.
- R7: An output word is {new-data, error, sample[13:0]}. Every new-data flag is set when a sample is accepted. A flag is cleared when a single read or a burst word returns its register.
- R8: The error bit of each output word is the OR of the 16-bit `err_flags` input. Reading byte address 0x3C returns `err_flags` unchanged.
- R9: A sample is accepted on a clock where `sample_valid` and `sample_ready` are both high. `sample_ready` is low exactly while a burst is in progress.
- R10: If chip select rises part way through a frame, the frame is discarded, the bit count restarts and the pending return word becomes 0x0000. Chip select rising at any time ends a burst.
- R11: Writes to any address outside the control range have no effect. Reads of unassigned addresses return 0x0000. Byte address 0x56 reads the `ID_VALUE` parameter (default 0x5A3C).
- R12: After reset, all control words, samples and new-data flags are zero, `sample_ready` is high, and the first frame returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_en | output | 1 | High while chip select is seen low (drive enable for MISO) |
| sample_valid | input | 1 | A new sample set is offered |
| sample_ready | output | 1 | Sample set can be taken this clock |
| sample_data | input | 98 | Seven 14-bit samples, channel k at bits [14k+13:14k] |
| err_flags | input | 16 | Error flags, readable at 0x3C and ORed into bit 14 |
| ctrl_q | output | 256 | Control words, word k at bits [16k+15:16k] (word k at byte 0x1A+2k) |

## Verification
The SPI pins pass through a two-stage synchronizer, so a received frame is decoded three clocks after the final SCLK rise. The return word is loaded one clock later, and `sample_ready` follows a burst start or end one clock after the decode. The bench holds each SCLK phase for six clocks and samples MISO only at the end of the low phase, just before it raises SCLK. Its model updates state after the frame's tail wait. The clock-by-clock comparison of `sample_ready` runs only in the idle gaps between frames, where every due change has already settled.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int WORD_W  = ADDR_W - 1;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } frame_t;
endpackage

// File: rtl/spi_rs_front.sv
module spi_rs_front
  import spi_rs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               spi_miso,
  output logic               spi_miso_en,
  output logic               cs_active,
  output logic               frame_done,
  output frame_t             frame_q,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [2:0]         sclk_s;
  logic [1:0]         cs_s;
  logic [1:0]         mosi_s;
  logic               rise, fall;
  logic               shift_pend;
  logic [FRAME_W-2:0] rx_sh;
  logic [FRAME_W-1:0] tx_sh;

  // two-stage synchronizers, plus one stage on SCLK for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 3'b111;
      cs_s   <= 2'b11;
      mosi_s <= 2'b00;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  assign cs_active   = ~cs_s[1];
  assign rise        = sclk_s[1] & ~sclk_s[2];
  assign fall        = ~sclk_s[1] & sclk_s[2];
  assign spi_miso    = tx_sh[FRAME_W-1];
  assign spi_miso_en = cs_active;

  // receive side: bit counter, shift-in, frame completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shift_pend <= 1'b0;
      rx_sh      <= '0;
      frame_done <= 1'b0;
      frame_q    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!cs_active) begin
        bit_cnt    <= '0;
        shift_pend <= 1'b0;
        rx_sh      <= '0;
      end else if (rise) begin
        rx_sh <= {rx_sh[FRAME_W-3:0], mosi_s[1]};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          shift_pend <= 1'b0;
          frame_done <= 1'b1;
          frame_q    <= {rx_sh, mosi_s[1]};
        end else begin
          bit_cnt    <= bit_cnt + 1'b1;
          shift_pend <= 1'b1;
        end
      end else if (fall) begin
        shift_pend <= 1'b0;
      end
    end
  end

  // transmit side: load the return word at frame end, shift on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (frame_done) begin
      tx_sh <= tx_word;
    end else if (!cs_active && bit_cnt != '0) begin
      tx_sh <= '0;
    end else if (cs_active && fall && shift_pend) begin
      tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_rs_burst.sv
module spi_rs_burst #(
  parameter int NUM_OUT = 7,
  localparam int IDX_W  = $clog2(NUM_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             frame_done,
  input  logic             start_req,
  output logic             burst_active,
  output logic [IDX_W-1:0] burst_idx,
  output logic             load_vld,
  output logic [IDX_W-1:0] load_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OUT - 1);

  always_comb begin
    load_vld = frame_done && ((burst_active && burst_idx != LAST) ||
                              (!burst_active && start_req));
    load_idx = burst_active ? burst_idx + IDX_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_active <= 1'b0;
      burst_idx    <= '0;
    end else if (!cs_active) begin
      burst_active <= 1'b0;
      burst_idx    <= '0;
    end else if (frame_done) begin
      if (burst_active) begin
        if (burst_idx == LAST) begin
          burst_active <= 1'b0;
          burst_idx    <= '0;
        end else begin
          burst_idx <= burst_idx + IDX_W'(1);
        end
      end else if (start_req) begin
        burst_active <= 1'b1;
        burst_idx    <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_rs_regs.sv
module spi_rs_regs
  import spi_rs_pkg::*;
#(
  parameter int                NUM_OUT     = 7,
  parameter int                SMP_W       = 14,
  parameter int                OUT_BASE    = 2,
  parameter int                NUM_CTRL    = 16,
  parameter int                CTRL_BASE   = 13,
  parameter int                STATUS_WORD = 30,
  parameter int                ID_WORD     = 43,
  parameter logic [ADDR_W-1:0] BURST_ADDR  = 7'h3E,
  parameter logic [FRAME_W-1:0] ID_VALUE   = 16'h5A3C,
  localparam int IDX_W  = $clog2(NUM_OUT),
  localparam int CIDX_W = $clog2(NUM_CTRL)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_active,
  input  logic                        frame_done,
  input  frame_t                      frame_q,
  input  logic [FRAME_W-1:0]          err_flags,
  input  logic                        sample_valid,
  input  logic [NUM_OUT*SMP_W-1:0]    sample_data,
  output logic                        sample_ready,
  output logic [FRAME_W-1:0]          tx_word,
  output logic [NUM_CTRL*FRAME_W-1:0] ctrl_q,
  output logic [NUM_OUT-1:0]          nd_q,
  output logic                        burst_active,
  output logic [IDX_W-1:0]            burst_idx
);
  localparam logic [WORD_W-1:0] OUT_LO = WORD_W'(OUT_BASE);
  localparam logic [WORD_W-1:0] OUT_HI = WORD_W'(OUT_BASE + NUM_OUT);
  localparam logic [WORD_W-1:0] CTL_LO = WORD_W'(CTRL_BASE);
  localparam logic [WORD_W-1:0] CTL_HI = WORD_W'(CTRL_BASE + NUM_CTRL);
  localparam logic [WORD_W-1:0] ST_WD  = WORD_W'(STATUS_WORD);
  localparam logic [WORD_W-1:0] ID_WD  = WORD_W'(ID_WORD);

  logic [WORD_W-1:0]  word;
  logic               err_any, start_req, rd_vld, wr_vld, accept;
  logic               out_hit, ctl_hit, load_vld;
  logic [IDX_W-1:0]   out_k, load_idx;
  logic [CIDX_W-1:0]  ctl_k;
  logic [FRAME_W-1:0] rd_mux;
  logic [FRAME_W-1:0] out_word [NUM_OUT];
  logic [FRAME_W-1:0] ctrl_w   [NUM_CTRL];

  assign word      = frame_q.addr[ADDR_W-1:1];
  assign err_any   = |err_flags;
  assign start_req = !frame_q.wr && frame_q.addr == BURST_ADDR;
  assign rd_vld    = frame_done && !burst_active && !frame_q.wr && !start_req;
  assign wr_vld    = frame_done && !burst_active && frame_q.wr;
  assign out_hit   = word >= OUT_LO && word < OUT_HI;
  assign ctl_hit   = word >= CTL_LO && word < CTL_HI;
  assign out_k     = IDX_W'(word - OUT_LO);
  assign ctl_k     = CIDX_W'(word - CTL_LO);
  assign sample_ready = !burst_active;
  assign accept    = sample_valid && sample_ready;

  spi_rs_burst #(.NUM_OUT(NUM_OUT)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_active   (cs_active),
    .frame_done  (frame_done),
    .start_req   (start_req),
    .burst_active(burst_active),
    .burst_idx   (burst_idx),
    .load_vld    (load_vld),
    .load_idx    (load_idx)
  );

  // output sample words with new-data flags
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic             nd_r, nd_clr;
    logic [SMP_W-1:0] data_r;
    assign nd_clr = (load_vld && load_idx == IDX_W'(k)) ||
                    (rd_vld && out_hit && out_k == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nd_r   <= 1'b0;
        data_r <= '0;
      end else if (accept) begin
        nd_r   <= 1'b1;
        data_r <= sample_data[k*SMP_W +: SMP_W];
      end else if (nd_clr) begin
        nd_r <= 1'b0;
      end
    end
    assign nd_q[k]     = nd_r;
    assign out_word[k] = {nd_r, err_any, data_r};
  end

  // control words, written one byte per frame
  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctl
    logic [FRAME_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (wr_vld && ctl_hit && ctl_k == CIDX_W'(k)) begin
        if (frame_q.addr[0]) r[15:8] <= frame_q.data;
        else                 r[7:0]  <= frame_q.data;
      end
    end
    assign ctrl_w[k]                   = r;
    assign ctrl_q[k*FRAME_W +: FRAME_W] = r;
  end

  always_comb begin
    rd_mux = '0;
    if (out_hit)            rd_mux = out_word[out_k];
    else if (ctl_hit)       rd_mux = ctrl_w[ctl_k];
    else if (word == ST_WD) rd_mux = err_flags;
    else if (word == ID_WD) rd_mux = ID_VALUE;
  end

  always_comb begin
    if (load_vld)    tx_word = out_word[load_idx];
    else if (rd_vld) tx_word = rd_mux;
    else             tx_word = '0;
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_rs_pkg::*;
#(
  parameter int NUM_OUT  = 7,
  parameter int SMP_W    = 14,
  parameter int NUM_CTRL = 16,
  parameter logic [FRAME_W-1:0] ID_VALUE = 16'h5A3C
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sclk,
  input  logic                        spi_cs_n,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic                        spi_miso_en,
  input  logic                        sample_valid,
  output logic                        sample_ready,
  input  logic [NUM_OUT*SMP_W-1:0]    sample_data,
  input  logic [FRAME_W-1:0]          err_flags,
  output logic [NUM_CTRL*FRAME_W-1:0] ctrl_q
);
  localparam int IDX_W = $clog2(NUM_OUT);

  logic               cs_active, frame_done, burst_active;
  frame_t             frame_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] tx_word;
  logic [NUM_OUT-1:0] nd_q;
  logic [IDX_W-1:0]   burst_idx;

  spi_rs_front u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .tx_word    (tx_word),
    .spi_miso   (spi_miso),
    .spi_miso_en(spi_miso_en),
    .cs_active  (cs_active),
    .frame_done (frame_done),
    .frame_q    (frame_q),
    .bit_cnt    (bit_cnt)
  );

  spi_rs_regs #(
    .NUM_OUT (NUM_OUT),
    .SMP_W   (SMP_W),
    .NUM_CTRL(NUM_CTRL),
    .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_active   (cs_active),
    .frame_done  (frame_done),
    .frame_q     (frame_q),
    .err_flags   (err_flags),
    .sample_valid(sample_valid),
    .sample_data (sample_data),
    .sample_ready(sample_ready),
    .tx_word     (tx_word),
    .ctrl_q      (ctrl_q),
    .nd_q        (nd_q),
    .burst_active(burst_active),
    .burst_idx   (burst_idx)
  );
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
  parameter int NUM_OUT  = 7,
  parameter int NUM_CTRL = 16,
  localparam int IDX_W   = $clog2(NUM_OUT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_active,
  input logic                  frame_done,
  input logic [3:0]            bit_cnt,
  input logic                  sample_valid,
  input logic                  sample_ready,
  input logic [NUM_OUT-1:0]    nd_q,
  input logic                  burst_active,
  input logic [IDX_W-1:0]      burst_idx,
  input logic [NUM_CTRL*16-1:0] ctrl_q
);
  // R10: an inactive chip select restarts the bit count
  a_r10_idle_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> bit_cnt == 4'd0);

  // R10: an inactive chip select ends any burst
  a_r10_cs_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !burst_active);

  // R7: an accepted sample raises every new-data flag
  a_r7_nd_set_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && sample_ready) |=> (&nd_q));

  // R7: new-data flags only drop on a decoded frame
  a_r7_nd_clears_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ((~nd_q & $past(nd_q)) == '0));

  // R3: control words change only on a decoded frame
  a_r3_ctrl_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(ctrl_q));

  // R6: burst position rests at zero outside a burst
  a_r6_idx_zero_outside_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |-> burst_idx == '0);
endmodule

bind spi_regslave spi_regslave_chk #(.NUM_OUT(NUM_OUT), .NUM_CTRL(NUM_CTRL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_active   (cs_active),
  .frame_done  (frame_done),
  .bit_cnt     (bit_cnt),
  .sample_valid(sample_valid),
  .sample_ready(sample_ready),
  .nd_q        (nd_q),
  .burst_active(burst_active),
  .burst_idx   (burst_idx),
  .ctrl_q      (ctrl_q)
);

// File: tb/sim_spi_regslave.sv
`timescale 1ns/1ps
module sim_spi_regslave;
  localparam int NOUT = 7;
  localparam int NCTL = 16;
  localparam int HP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_en, s_valid = 1'b0, s_ready;
  logic [NOUT*14-1:0] s_data = '0;
  logic [15:0] err = 16'h0000;
  logic [NCTL*16-1:0] ctrl_q;

  int n_cmp = 0, n_bad = 0;
  bit quiet = 1'b0, fin = 1'b0;

  // behavioural model state
  logic [13:0] m_data [NOUT];
  bit          m_nd   [NOUT];
  logic [15:0] m_ctrl [NCTL];
  logic [15:0] m_exp  = 16'h0000;
  bit          m_burst = 1'b0;
  int          m_idx = 0;

  always #5 clk = ~clk;

  spi_regslave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .sample_valid(s_valid),
    .sample_ready(s_ready), .sample_data(s_data), .err_flags(err), .ctrl_q(ctrl_q)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_word(int k);
    return {m_nd[k], |err, m_data[k]};
  endfunction

  function automatic logic [15:0] m_read(int w);
    if (w >= 2 && w < 2 + NOUT)   return m_word(w - 2);
    if (w >= 13 && w < 13 + NCTL) return m_ctrl[w - 13];
    if (w == 30) return err;
    if (w == 43) return 16'h5A3C;
    return 16'h0000;
  endfunction

  task automatic m_frame(input logic [15:0] din);
    int w;
    w = int'(din[14:9]);
    if (m_burst) begin
      if (m_idx == NOUT - 1) begin m_burst = 0; m_idx = 0; m_exp = 16'h0000; end
      else begin m_idx++; m_exp = m_word(m_idx); m_nd[m_idx] = 0; end
    end else if (!din[15] && din[14:8] == 7'h3E) begin
      m_burst = 1; m_idx = 0; m_exp = m_word(0); m_nd[0] = 0;
    end else if (!din[15]) begin
      m_exp = m_read(w);
      if (w >= 2 && w < 2 + NOUT) m_nd[w - 2] = 0;
    end else begin
      if (w >= 13 && w < 13 + NCTL) begin
        if (din[8]) m_ctrl[w - 13][15:8] = din[7:0];
        else        m_ctrl[w - 13][7:0]  = din[7:0];
      end
      m_exp = 16'h0000;
    end
  endtask

  // one 16-bit frame; the returned word is compared with the model
  task automatic frame(input logic [15:0] din, input bit hold, input string tag);
    logic [15:0] got;
    quiet = 0;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b0; mosi = din[i];
      repeat (HP) @(negedge clk);
      got[i] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
    end
    chk(got, m_exp, tag);
    m_frame(din);
    if (!hold) begin cs_n = 1'b1; m_burst = 0; m_idx = 0; end
    repeat (HP + 2) @(negedge clk);
    quiet = 1;
  endtask

  task automatic abort_frame(input int nbits);
    quiet = 0;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; mosi = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
    end
    cs_n = 1'b1;
    m_burst = 0; m_idx = 0;
    if (nbits > 0) m_exp = 16'h0000;
    repeat (HP + 2) @(negedge clk);
    quiet = 1;
  endtask

  task automatic push(input logic [13:0] base);
    @(negedge clk);
    for (int k = 0; k < NOUT; k++) s_data[k*14 +: 14] = base + 14'(k * 'h111);
    s_valid = 1'b1;
    chk({15'b0, s_ready}, 16'h0001, "R9 ready before accept");
    @(negedge clk);
    s_valid = 1'b0;
    for (int k = 0; k < NOUT; k++) begin m_data[k] = s_data[k*14 +: 14]; m_nd[k] = 1; end
  endtask

  // clock-by-clock comparison of sample_ready during idle gaps
  always @(negedge clk) begin
    if (quiet && !fin) chk({15'b0, s_ready}, {15'b0, !m_burst}, "R9 ready tracks burst");
  end

  task automatic finish_run;
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NOUT; k++) begin m_data[k] = '0; m_nd[k] = 0; end
    for (int k = 0; k < NCTL; k++) m_ctrl[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({15'b0, s_ready}, 16'h0001, "R12 ready after reset");
    chk({15'b0, miso_en}, 16'h0000, "R12 miso_en idle");
    quiet = 1;

    frame(16'h1A00, 0, "R12 first frame");
    frame(16'h5600, 0, "R12 control reset value");
    frame(16'h0400, 0, "R1 id word");
    frame(16'h3600, 0, "R12 output reset value");
    frame(16'hB703, 0, "R4 control read");
    frame(16'h3700, 0, "R5 after write");
    frame(16'hB6A5, 0, "R2 odd-address write landed");
    frame(16'h3600, 0, "R5 after write");
    frame(16'h8455, 0, "R3 both bytes");
    frame(16'hBC77, 0, "R5 after write");
    frame(16'hD612, 0, "R5 after write");
    frame(16'hBA34, 0, "R5 after write");
    frame(16'h3A00, 0, "R5 after write");
    frame(16'h5600, 0, "R11 reserved reads zero");
    frame(16'h0400, 0, "R11 id not written");
    frame(16'h3700, 0, "R11 output not written");
    frame(16'h3600, 0, "R4 odd address full word");

    push(14'h1234);
    frame(16'h0800, 0, "R3 control word");
    frame(16'h0900, 0, "R7 new data set");
    frame(16'h0000, 0, "R7 new data cleared");
    err = 16'h0040;
    frame(16'h3C00, 0, "R11 reserved");
    frame(16'h0A00, 0, "R8 status word");
    frame(16'h0000, 0, "R8 error bit merged");
    err = 16'h0000;

    push(14'h0ABC);
    frame(16'h3E00, 1, "R11 reserved");
    frame(16'hB7FF, 1, "R6 burst word 0");
    frame(16'hB7FF, 1, "R6 burst word 1");
    quiet = 0;
    s_valid = 1'b1;
    s_data = '1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({15'b0, s_ready}, 16'h0000, "R9 ready low in burst");
    end
    s_valid = 1'b0;
    quiet = 1;
    for (int i = 2; i < NOUT; i++) frame(16'hB6FF, 1, "R6 burst word");
    frame(16'h3600, 0, "R6 zero after burst");
    frame(16'h0400, 0, "R6 burst frames ignored");
    frame(16'h0000, 0, "R7 burst cleared flag");

    frame(16'h3600, 0, "R11 reserved");
    abort_frame(6);
    frame(16'h3600, 0, "R10 aborted frame");
    frame(16'h0000, 0, "R10 control unchanged");

    push(14'h2001);
    frame(16'h3E00, 1, "R11 reserved");
    frame(16'h0000, 1, "R6 burst word 0");
    frame(16'h0000, 0, "R6 burst word 1");
    frame(16'h0800, 0, "R10 cs ends burst");
    frame(16'h0800, 0, "R7 flag left by burst");
    frame(16'h0000, 0, "R7 flag cleared by read");

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule